// File: doc/BRIEF.md
# Banked Stack-Pointer Control Register Unit

This unit holds a processor's control state behind a small index space: the status word with its two backup copies, a condition flag, two saved program counters, two scratch words, and whichever of the two stack pointers is not currently live. It has one combinational read port and one write port that commits on the rising clock edge. Both ports are addressed by a 4-bit control-register index.

The live stack pointer is an entry of the general register file, outside this unit. The unit reads it through `spIn` and can overwrite it through `spWe` and `spOut`, which the register file commits on the same edge. Bit 7 of the status word chooses the stack mode. Mode 0 uses the interrupt stack and mode 1 uses the user stack. A status-word write that flips this bit saves the live pointer into the bank that is being left and loads the other bank into the live entry in one cycle. Accesses to either stack-pointer index go to the live pointer when that bank is active, and to the stored copy when it is not.

Top module: `creg_bank`

## Requirements
- R1: A synchronous reset clears every stored register and the condition flag, so stack mode is 0 and every readable index other than 2 reads 0. Index 2 then reads `spIn`.
- R2: A write to index 0 does three things. It loads the backup status from `wrData[15:8]`. It loads the status from `wrData[7:0]`, with `wrData[7]` becoming the stack mode. It loads the condition flag from `wrData[0]`.
- R3: A read of index 0 is built from three fields, and all other bits read 0:
  - bits 15, 14 and 8 carry the matching bits of the backup status;
  - bits 7 and 6 carry status bits 7 and 6;
  - bit 0 carries the condition flag.
- R4: A write to index 0 that moves stack mode from 0 to 1 has two effects. In that cycle it asserts `spWe` with `spOut` equal to the stored user pointer. At the edge it saves `spIn` as the stored interrupt pointer.
- R5: A write to index 0 that moves stack mode from 1 to 0 has two effects. In that cycle it asserts `spWe` with `spOut` equal to the stored interrupt pointer. At the edge it saves `spIn` as the stored user pointer.
- R6: A write to index 0 that leaves the stack mode unchanged does not assert `spWe` and leaves both stored pointers unchanged.
- R7: Index 2 (interrupt pointer) maps to the live pointer in mode 0. There a read returns `spIn`, and a write drives `spWe`=1 with `spOut`=`wrData`. In mode 1 it reads and writes the stored interrupt pointer.
- R8: Index 3 (user pointer) maps to the live pointer in mode 1 and to the stored user pointer in mode 0, with the same read and write behaviour as R7.
- R9: Index 1 reads the condition flag in bit 0, with 0 in all other bits. A write to it changes only the flag, taken from `wrData[0]`.
- R10: Index 7 (second backup status) stores `wrData[7:0]` and reads back masked with 0xC1.
- R11: Indices 6 and 8 (saved program counters) store the written word and read back with bit 0 forced to 0.
- R12: Indices 4 and 5 are plain 32-bit read/write scratch words.
- R13: Indices 9 to 15 read as 0. Writes to them change no register and never assert `spWe`.
- R14: A read in the same cycle as a write to the same index returns the value held before the write. The new value appears after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| rdIdx | input | 4 | Read index |
| rdData | output | 32 | Combinational read data |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 4 | Write index |
| wrData | input | 32 | Write data |
| spIn | input | 32 | Current live stack pointer from the register file |
| spWe | output | 1 | Live stack pointer write strobe to the register file |
| spOut | output | 32 | New live stack pointer value |

## Verification
The hardest state to observe is the stored copy of the bank that is currently live. In that mode both stack-pointer indices hide it: one index points at the live entry and the other at the opposite bank. The bench therefore models the register-file entry itself. It fills the stored user pointer in mode 0, swaps into mode 1, and checks that the live entry received that value. It then writes the stored interrupt pointer from mode 1 and swaps back, so the values saved by each transition are read out through the indices after the mode has changed. A status write that keeps the mode bit at its current value is placed between the two swaps to show that it does not disturb either bank.

// File: rtl/creg_pkg.sv
package creg_pkg;

  localparam int DATA_W      = 32;
  localparam int IDX_W       = 4;
  localparam int BYTE_W      = 8;
  localparam int NUM_SCRATCH = 2;

  localparam int MODE_BIT    = 7;

  localparam logic [IDX_W-1:0] IDX_PSW   = 4'd0;
  localparam logic [IDX_W-1:0] IDX_COND  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_SPI   = 4'd2;
  localparam logic [IDX_W-1:0] IDX_SPU   = 4'd3;
  localparam int               IDX_SCR0  = 4;
  localparam logic [IDX_W-1:0] IDX_BPC   = 4'd6;
  localparam logic [IDX_W-1:0] IDX_BBPSW = 4'd7;
  localparam logic [IDX_W-1:0] IDX_BBPC  = 4'd8;

  // Write strobes produced by the decoder for the datapath.
  typedef struct packed {
    logic                   pswWe;
    logic                   condWe;
    logic                   bbpswWe;
    logic                   spiStoreWe;
    logic                   spuStoreWe;
    logic                   liveWe;
    logic                   bpcWe;
    logic                   bbpcWe;
    logic [NUM_SCRATCH-1:0] scrWe;
    logic                   saveToSpi;
    logic                   saveToSpu;
  } crStrobes_t;

endpackage

// File: rtl/creg_ctrl.sv
module creg_ctrl
  import creg_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic          wrEn,
  input  logic [IW-1:0] wrIdx,
  input  logic          newMode,
  input  logic          stackMode,
  output crStrobes_t    strb
);

  logic [NUM_SCRATCH-1:0] scrHit;

  generate
    for (genvar i = 0; i < NUM_SCRATCH; i++) begin : g_scrDec
      assign scrHit[i] = wrEn && (wrIdx == IW'(IDX_SCR0 + i));
    end
  endgenerate

  always_comb begin
    strb       = '0;
    strb.scrWe = scrHit;
    if (wrEn) begin
      unique case (wrIdx)
        IDX_PSW: begin
          strb.pswWe     = 1'b1;
          strb.saveToSpi = newMode && !stackMode;
          strb.saveToSpu = !newMode && stackMode;
        end
        IDX_COND:  strb.condWe = 1'b1;
        IDX_SPI: begin
          if (stackMode) strb.spiStoreWe = 1'b1;
          else           strb.liveWe     = 1'b1;
        end
        IDX_SPU: begin
          if (stackMode) strb.liveWe     = 1'b1;
          else           strb.spuStoreWe = 1'b1;
        end
        IDX_BPC:   strb.bpcWe   = 1'b1;
        IDX_BBPSW: strb.bbpswWe = 1'b1;
        IDX_BBPC:  strb.bbpcWe  = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/creg_dp.sv
module creg_dp
  import creg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  crStrobes_t    strb,
  input  logic [DW-1:0] wrData,
  input  logic [IW-1:0] rdIdx,
  input  logic [DW-1:0] spIn,
  output logic [DW-1:0] rdData,
  output logic          spWe,
  output logic [DW-1:0] spOut,
  output logic          stackMode,
  output logic [DW-1:0] spiStore,
  output logic [DW-1:0] spuStore
);

  // Only bits that some read can return are kept.
  logic [1:0]    pswHi;     // status bits 7:6
  logic [1:0]    bpswHi;    // backup status bits 7:6
  logic          bpswLo;    // backup status bit 0
  logic [1:0]    bbpswHi;
  logic          bbpswLo;
  logic          condQ;
  logic [DW-1:0] spiQ;
  logic [DW-1:0] spuQ;
  logic [DW-1:1] bpcQ;
  logic [DW-1:1] bbpcQ;
  logic [DW-1:0] scrQ [NUM_SCRATCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      pswHi   <= '0;
      bpswHi  <= '0;
      bpswLo  <= 1'b0;
      bbpswHi <= '0;
      bbpswLo <= 1'b0;
      condQ   <= 1'b0;
      spiQ    <= '0;
      spuQ    <= '0;
      bpcQ    <= '0;
      bbpcQ   <= '0;
    end else begin
      if (strb.pswWe) begin
        pswHi  <= wrData[MODE_BIT -: 2];
        bpswHi <= wrData[BYTE_W + MODE_BIT -: 2];
        bpswLo <= wrData[BYTE_W];
      end
      if (strb.pswWe || strb.condWe) condQ <= wrData[0];
      if (strb.bbpswWe) begin
        bbpswHi <= wrData[MODE_BIT -: 2];
        bbpswLo <= wrData[0];
      end
      if (strb.saveToSpi)       spiQ <= spIn;
      else if (strb.spiStoreWe) spiQ <= wrData;
      if (strb.saveToSpu)       spuQ <= spIn;
      else if (strb.spuStoreWe) spuQ <= wrData;
      if (strb.bpcWe)  bpcQ  <= wrData[DW-1:1];
      if (strb.bbpcWe) bbpcQ <= wrData[DW-1:1];
    end
  end

  generate
    for (genvar i = 0; i < NUM_SCRATCH; i++) begin : g_scr
      always_ff @(posedge clk) begin
        if (rst)               scrQ[i] <= '0;
        else if (strb.scrWe[i]) scrQ[i] <= wrData;
      end
    end
  endgenerate

  assign stackMode = pswHi[1];
  assign spiStore  = spiQ;
  assign spuStore  = spuQ;

  // Live stack pointer update toward the register file.
  assign spWe  = strb.liveWe || strb.saveToSpi || strb.saveToSpu;
  always_comb begin
    if (strb.saveToSpi)      spOut = spuQ;
    else if (strb.saveToSpu) spOut = spiQ;
    else                     spOut = wrData;
  end

  // Read mux.
  logic [DW-1:0] scrRd;
  always_comb begin
    scrRd = '0;
    for (int i = 0; i < NUM_SCRATCH; i++)
      if (rdIdx == IW'(IDX_SCR0 + i)) scrRd = scrQ[i];
  end

  always_comb begin
    rdData = '0;
    unique case (rdIdx)
      IDX_PSW: begin
        rdData[BYTE_W + MODE_BIT -: 2] = bpswHi;
        rdData[BYTE_W]                 = bpswLo;
        rdData[MODE_BIT -: 2]          = pswHi;
        rdData[0]                      = condQ;
      end
      IDX_COND:  rdData[0] = condQ;
      IDX_SPI:   rdData = stackMode ? spiQ : spIn;
      IDX_SPU:   rdData = stackMode ? spIn : spuQ;
      IDX_BPC:   rdData = {bpcQ, 1'b0};
      IDX_BBPSW: begin
        rdData[MODE_BIT -: 2] = bbpswHi;
        rdData[0]             = bbpswLo;
      end
      IDX_BBPC:  rdData = {bbpcQ, 1'b0};
      default:   rdData = scrRd;
    endcase
  end

endmodule

// File: rtl/creg_bank.sv
module creg_bank
  import creg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rdIdx,
  output logic [DW-1:0] rdData,
  input  logic          wrEn,
  input  logic [IW-1:0] wrIdx,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] spIn,
  output logic          spWe,
  output logic [DW-1:0] spOut
);

  crStrobes_t    strb;
  logic          stackMode;
  logic [DW-1:0] spiStore;
  logic [DW-1:0] spuStore;

  creg_ctrl #(.IW(IW)) ctrl_i (
    .wrEn      (wrEn),
    .wrIdx     (wrIdx),
    .newMode   (wrData[MODE_BIT]),
    .stackMode (stackMode),
    .strb      (strb)
  );

  creg_dp #(.DW(DW), .IW(IW)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .wrData    (wrData),
    .rdIdx     (rdIdx),
    .spIn      (spIn),
    .rdData    (rdData),
    .spWe      (spWe),
    .spOut     (spOut),
    .stackMode (stackMode),
    .spiStore  (spiStore),
    .spuStore  (spuStore)
  );

endmodule

// File: rtl/creg_chk.sv
module creg_chk
  import creg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input logic          clk,
  input logic          rst,
  input logic [IW-1:0] rdIdx,
  input logic [DW-1:0] rdData,
  input logic          wrEn,
  input logic [IW-1:0] wrIdx,
  input logic [DW-1:0] wrData,
  input logic [DW-1:0] spIn,
  input logic          spWe,
  input logic [DW-1:0] spOut,
  input logic          stackMode,
  input logic [DW-1:0] spiStore,
  input logic [DW-1:0] spuStore
);

  logic pswWr;
  assign pswWr = wrEn && (wrIdx == IDX_PSW);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!stackMode && spiStore == '0 && spuStore == '0));

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (rst)
    pswWr |=> (stackMode == $past(wrData[MODE_BIT])));

  assert_swap_out_R4: assert property (@(posedge clk) disable iff (rst)
    (pswWr && wrData[MODE_BIT] && !stackMode) |-> (spWe && spOut == spuStore));

  assert_swap_save_R4: assert property (@(posedge clk) disable iff (rst)
    (pswWr && wrData[MODE_BIT] && !stackMode) |=> (spiStore == $past(spIn)));

  assert_swap_save_R5: assert property (@(posedge clk) disable iff (rst)
    (pswWr && !wrData[MODE_BIT] && stackMode) |=> (spuStore == $past(spIn) && !stackMode));

  assert_no_swap_R6: assert property (@(posedge clk) disable iff (rst)
    (pswWr && (wrData[MODE_BIT] == stackMode)) |-> !spWe);

  assert_even_pc_R11: assert property (@(posedge clk) disable iff (rst)
    (rdIdx == IDX_BPC || rdIdx == IDX_BBPC) |-> !rdData[0]);

  assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (rst)
    (rdIdx > IDX_BBPC) |-> (rdData == '0));

  assert_unmapped_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    (!wrEn || wrIdx > IDX_BBPC) |-> !spWe);

endmodule

bind creg_bank creg_chk #(.DW(DW), .IW(IW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rdIdx     (rdIdx),
  .rdData    (rdData),
  .wrEn      (wrEn),
  .wrIdx     (wrIdx),
  .wrData    (wrData),
  .spIn      (spIn),
  .spWe      (spWe),
  .spOut     (spOut),
  .stackMode (stackMode),
  .spiStore  (spiStore),
  .spuStore  (spuStore)
);

// File: tb/creg_bank_tb_top.sv
module creg_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rdIdx = '0;
  logic [31:0] rdData;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic [31:0] spIn;
  logic        spWe;
  logic [31:0] spOut;

  logic [31:0] gprSp = 32'h0000_1000;  // model of the register-file entry
  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign spIn = gprSp;
  always @(posedge clk) if (spWe) gprSp <= spOut;

  creg_bank dut_i (
    .clk(clk), .rst(rst), .rdIdx(rdIdx), .rdData(rdData),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .spIn(spIn), .spWe(spWe), .spOut(spOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrCycle(input logic [3:0] idx, input logic [31:0] data,
                         input logic expWe, input logic [31:0] expOut, input string req);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = data;
    #1;
    chk(req, {31'b0, spWe}, {31'b0, expWe});
    if (expWe) chk(req, spOut, expOut);
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] idx, input logic [31:0] exp, input string req);
    @(negedge clk);
    rdIdx = idx;
    #1 chk(req, rdData, exp);
  endtask

  task automatic tReset();
    for (int i = 0; i < 16; i++) begin
      if (i == 2) rdChk(4'(i), 32'h0000_1000, "R1");
      else        rdChk(4'(i), 32'h0, "R1");
    end
  endtask

  task automatic tPsw();
    wrCycle(4'd0, 32'h0000_FF41, 1'b0, '0, "R6");
    rdChk(4'd0, 32'h0000_C141, "R2");
    rdChk(4'd0, 32'h0000_C141, "R3");
    rdChk(4'd2, 32'h0000_1000, "R6");
  endtask

  task automatic tCond();
    wrCycle(4'd1, 32'hFFFF_FFFE, 1'b0, '0, "R9");
    rdChk(4'd1, 32'h0, "R9");
    rdChk(4'd0, 32'h0000_C140, "R9");
    wrCycle(4'd1, 32'h0000_0003, 1'b0, '0, "R9");
    rdChk(4'd1, 32'h1, "R9");
    rdChk(4'd0, 32'h0000_C141, "R9");
  endtask

  task automatic tBanking();
    wrCycle(4'd3, 32'h0000_2000, 1'b0, '0, "R8");
    rdChk(4'd3, 32'h0000_2000, "R8");
    wrCycle(4'd2, 32'h0000_1111, 1'b1, 32'h0000_1111, "R7");
    rdChk(4'd2, 32'h0000_1111, "R7");
    chk("R7", gprSp, 32'h0000_1111);
    wrCycle(4'd0, 32'h0000_0080, 1'b1, 32'h0000_2000, "R4");
    chk("R4", gprSp, 32'h0000_2000);
    rdChk(4'd0, 32'h0000_0080, "R2");
    rdChk(4'd2, 32'h0000_1111, "R4");
    rdChk(4'd3, 32'h0000_2000, "R8");
    wrCycle(4'd3, 32'h0000_2222, 1'b1, 32'h0000_2222, "R8");
    chk("R8", gprSp, 32'h0000_2222);
    wrCycle(4'd2, 32'h0000_3333, 1'b0, '0, "R7");
    rdChk(4'd2, 32'h0000_3333, "R7");
    wrCycle(4'd0, 32'h0000_0080, 1'b0, '0, "R6");
    chk("R6", gprSp, 32'h0000_2222);
    rdChk(4'd2, 32'h0000_3333, "R6");
    wrCycle(4'd0, 32'h0000_0000, 1'b1, 32'h0000_3333, "R5");
    chk("R5", gprSp, 32'h0000_3333);
    rdChk(4'd3, 32'h0000_2222, "R5");
    rdChk(4'd2, 32'h0000_3333, "R5");
    rdChk(4'd0, 32'h0, "R5");
  endtask

  task automatic tBbpsw();
    wrCycle(4'd7, 32'hFFFF_FFFF, 1'b0, '0, "R10");
    rdChk(4'd7, 32'h0000_00C1, "R10");
    wrCycle(4'd7, 32'h0000_013E, 1'b0, '0, "R10");
    rdChk(4'd7, 32'h0, "R10");
  endtask

  task automatic tBackupPc();
    wrCycle(4'd6, 32'h1234_5679, 1'b0, '0, "R11");
    rdChk(4'd6, 32'h1234_5678, "R11");
    wrCycle(4'd8, 32'hFFFF_FFFF, 1'b0, '0, "R11");
    rdChk(4'd8, 32'hFFFF_FFFE, "R11");
  endtask

  task automatic tScratch();
    wrCycle(4'd4, 32'hDEAD_BEEF, 1'b0, '0, "R12");
    wrCycle(4'd5, 32'h0BAD_F00D, 1'b0, '0, "R12");
    rdChk(4'd4, 32'hDEAD_BEEF, "R12");
    rdChk(4'd5, 32'h0BAD_F00D, "R12");
  endtask

  task automatic tReadDuringWrite();
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 4'd4; wrData = 32'h5555_AAAA; rdIdx = 4'd4;
    #1 chk("R14", rdData, 32'hDEAD_BEEF);
    @(posedge clk);
    #1 wrEn = 1'b0;
    chk("R14", rdData, 32'h5555_AAAA);
  endtask

  task automatic tUnmapped();
    for (int i = 9; i < 16; i++) wrCycle(4'(i), 32'hFFFF_FFFF, 1'b0, '0, "R13");
    for (int i = 9; i < 16; i++) rdChk(4'(i), 32'h0, "R13");
    rdChk(4'd4, 32'h5555_AAAA, "R13");
    rdChk(4'd5, 32'h0BAD_F00D, "R13");
    rdChk(4'd0, 32'h0, "R13");
    rdChk(4'd6, 32'h1234_5678, "R13");
    rdChk(4'd7, 32'h0, "R13");
    rdChk(4'd2, 32'h0000_3333, "R13");
    chk("R13", gprSp, 32'h0000_3333);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    tReset();
    tPsw();
    tCond();
    tBanking();
    tBbpsw();
    tBackupPc();
    tScratch();
    tReadDuringWrite();
    tUnmapped();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL R14: watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule